// File: doc/BRIEF.md
# Completion Ring Write Engine

This block places completion records for the transmit and receive paths into a circular ring held in host memory. A completion request carries a buffer index, a byte length and a flag that says whether it belongs to the transmit or the receive path. The engine works out the ring slot for the request, computes that slot's host address and puts a DMA write request on its output, tagged with the slot's pointer value.

The block keeps two head pointers. The speculative head counts every write it has issued. The committed head is the pointer the host sees, and it moves only when a write-done response comes back in order. Each in-order response advances the committed head by one and produces one event request. The event type, transmit-completion or receive-completion, follows the flag of the original request. The host tells the block how far it has consumed the ring by writing the tail pointer through the configuration port. The ring base address and the ring size are loaded through the same port.

Top module: `cpl_ring_writer`

## Requirements
- R1: After a synchronous active-low reset, `head_ptr` is 0, `dma_valid`, `evt_valid` and `tag_err` are low, and `req_ready` is high.
- R2: The DMA address is `base + (spec_head & (size-1)) * 32`, where the record size is 32 bytes. The ring size is 2^N, with N written through `reg_sel`=1 (bits [4:0] of `reg_wdata`). The base is written through `reg_sel`=0 and the tail through `reg_sel`=2 (bits [15:0]).
- R3: `dma_type` is 2 for a transmit request (`req_is_tx`=1) and 3 for a receive request. `dma_index` and `dma_len` repeat the request's index and length.
- R4: Each issued write has `dma_tag` equal to the 16-bit speculative head, and the speculative head then increments by one.
- R5: A request is full when `(spec_head - tail) mod 65536 >= size`. A full request is consumed with `req_reject` high in its handshake cycle, issues no DMA write and leaves the speculative head unchanged. A tail ahead of the speculative head wraps to a large difference and counts as full.
- R6: A write-done whose `done_tag` equals `head_ptr` advances `head_ptr` by exactly one and raises `evt_valid` on the next cycle.
- R7: `evt_kind` is 0 for a transmit completion and 1 for a receive completion, matching the flag of the request that created the tag.
- R8: A write-done whose tag differs from `head_ptr` sets the sticky `tag_err`, leaves `head_ptr` unchanged and raises no event.
- R9: While `dma_valid` is high and `dma_ready` is low, the DMA outputs hold steady and `req_ready` is low. At most one request is taken per cycle.
- R10: `req_ready` is low while the number of issued but uncommitted writes equals OUT_DEPTH (8).
- R11: `evt_valid` and `evt_kind` hold until `evt_ready`. `done_ready` is low while an event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_sel | input | 2 | Configuration target: 0 base, 1 log2 size, 2 tail |
| reg_wdata | input | 64 | Configuration write data |
| head_ptr | output | 16 | Committed head pointer seen by the host |
| req_valid | input | 1 | Completion request valid |
| req_ready | output | 1 | Completion request accepted this cycle |
| req_index | input | 16 | Buffer index of the completion |
| req_len | input | 16 | Byte length of the completion |
| req_is_tx | input | 1 | 1 for transmit, 0 for receive |
| req_reject | output | 1 | Request consumed but dropped because the ring is full |
| dma_valid | output | 1 | DMA write request valid |
| dma_ready | input | 1 | DMA write request taken |
| dma_addr | output | 64 | Host address of the ring slot |
| dma_type | output | 3 | Operation type code (2 tx, 3 rx) |
| dma_tag | output | 16 | Slot pointer used as the tag |
| dma_index | output | 16 | Record field: buffer index |
| dma_len | output | 16 | Record field: byte length |
| done_valid | input | 1 | Write-done response valid |
| done_ready | output | 1 | Write-done response accepted |
| done_tag | input | 16 | Tag of the finished write |
| evt_valid | output | 1 | Event request valid |
| evt_ready | input | 1 | Event request taken |
| evt_kind | output | 1 | 0 transmit-completion, 1 receive-completion |
| tag_err | output | 1 | Sticky out-of-order response flag |

## Verification
The assertions check the handshake rules on every cycle: held DMA and event outputs under back-pressure, legal type codes, a committed head that only ever steps by one, a sticky error flag, no write after a rejected request, and an event after every in-order response. The exact slot addresses across a ring wrap, the full decision with a tail ahead of the head, the mapping of the flag onto event kinds and the outstanding-write limit depend on the values of a sequence of requests. Only the bench's scenarios show these.

// File: rtl/cpl_ring_pkg.sv
`timescale 1ns/1ps
// Package: shared codes for the completion ring write engine.
// Assumes: the operation type codes are shared with the DMA transport.
package cpl_ring_pkg;
    typedef enum logic [2:0] {
        OP_DESC_FETCH = 3'd0,
        OP_BUF_DATA   = 3'd1,
        OP_TX_CPL     = 3'd2,
        OP_RX_CPL     = 3'd3,
        OP_EVENT      = 3'd4
    } op_code_e;

    typedef enum logic {
        EV_TX_DONE = 1'b0,
        EV_RX_DONE = 1'b1
    } ev_kind_e;

    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_SIZE = 2'd1;
    localparam logic [1:0] SEL_TAIL = 2'd2;
endpackage

// File: rtl/cpl_ptr_track.sv
`timescale 1ns/1ps
// Module: cpl_ptr_track
// Holds the speculative head, the committed head and the host tail, and
// derives the full and outstanding-room conditions from them.
// Assumes: issue and commit are single-cycle pulses qualified by the caller.
module cpl_ptr_track #(
    parameter int PTR_W   = 16,
    parameter int LOG_W   = 5,
    parameter int OUT_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tail_we,
    input  logic [PTR_W-1:0] tail_in,
    input  logic [LOG_W-1:0] size_log2,
    input  logic             issue,
    input  logic             commit,
    output logic [PTR_W-1:0] spec_head,
    output logic [PTR_W-1:0] cmt_head,
    output logic             full,
    output logic             room
);
    localparam int OUT_DEPTH = 1 << OUT_LOG;

    logic [PTR_W-1:0] tail_q;
    logic [PTR_W-1:0] fill;
    logic [PTR_W-1:0] inflight;
    logic [PTR_W:0]   ring_size;

    // Pointer registers: heads step by one, tail loads from the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_head <= '0;
            cmt_head  <= '0;
            tail_q    <= '0;
        end else begin
            if (issue)   spec_head <= spec_head + 1'b1;
            if (commit)  cmt_head  <= cmt_head + 1'b1;
            if (tail_we) tail_q    <= tail_in;
        end
    end

    // Occupancy: modular distances compared against ring size and window.
    always_comb begin
        fill      = spec_head - tail_q;
        inflight  = spec_head - cmt_head;
        ring_size = (PTR_W+1)'(1) << size_log2;
        full      = {1'b0, fill} >= ring_size;
        room      = inflight < PTR_W'(OUT_DEPTH);
    end
endmodule

// File: rtl/cpl_addr_gen.sv
`timescale 1ns/1ps
// Module: cpl_addr_gen
// Computes the host address of the ring slot selected by a pointer.
// Assumes: ring size is a power of two and records are 2^REC_LOG2 bytes.
module cpl_addr_gen #(
    parameter int ADDR_W   = 64,
    parameter int PTR_W    = 16,
    parameter int LOG_W    = 5,
    parameter int REC_LOG2 = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LOG_W-1:0]  size_log2,
    input  logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] slot_addr
);
    logic [PTR_W:0]   ring_size;
    logic [PTR_W-1:0] mask;
    logic [PTR_W-1:0] slot;

    // Address arithmetic: mask the pointer, scale by record size, add base.
    always_comb begin
        ring_size = (PTR_W+1)'(1) << size_log2;
        mask      = PTR_W'(ring_size - 1'b1);
        slot      = ptr & mask;
        slot_addr = base + (ADDR_W'(slot) << REC_LOG2);
    end
endmodule

// File: rtl/cpl_kind_store.sv
`timescale 1ns/1ps
// Module: cpl_kind_store
// Remembers the tx/rx flag of each outstanding write, indexed by tag bits.
// Assumes: no more than 2^OUT_LOG writes are outstanding at once.
module cpl_kind_store #(
    parameter int OUT_LOG = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [OUT_LOG-1:0] wr_idx,
    input  logic               wr_is_tx,
    input  logic [OUT_LOG-1:0] rd_idx,
    output logic               rd_is_tx
);
    localparam int DEPTH = 1 << OUT_LOG;

    logic [DEPTH-1:0] is_tx_q;

    // One flag bit per slot of the outstanding window.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)                                is_tx_q[g] <= 1'b0;
                else if (wr_en && wr_idx == OUT_LOG'(g))   is_tx_q[g] <= wr_is_tx;
            end
        end
    endgenerate

    // Lookup of the flag for the tag being committed.
    always_comb rd_is_tx = is_tx_q[rd_idx];
endmodule

// File: rtl/cpl_ring_writer.sv
`timescale 1ns/1ps
// Module: cpl_ring_writer (top)
// Posts completion records to a host ring through DMA writes, commits them
// on in-order write-done responses and raises one event per commit.
// Assumes: the transport returns write-done responses in issue order.
module cpl_ring_writer
    import cpl_ring_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int PTR_W    = 16,
    parameter int LEN_W    = 16,
    parameter int REC_LOG2 = 5,
    parameter int OUT_LOG  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [PTR_W-1:0]  head_ptr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PTR_W-1:0]  req_index,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_is_tx,
    output logic              req_reject,
    output logic              dma_valid,
    input  logic              dma_ready,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [2:0]        dma_type,
    output logic [PTR_W-1:0]  dma_tag,
    output logic [PTR_W-1:0]  dma_index,
    output logic [LEN_W-1:0]  dma_len,
    input  logic              done_valid,
    output logic              done_ready,
    input  logic [PTR_W-1:0]  done_tag,
    output logic              evt_valid,
    input  logic              evt_ready,
    output logic              evt_kind,
    output logic              tag_err
);
    localparam int LOG_W = $clog2(PTR_W + 1);

    logic [ADDR_W-1:0] base_q;
    logic [LOG_W-1:0]  size_log2_q;
    logic [PTR_W-1:0]  spec_head;
    logic [ADDR_W-1:0] slot_addr;
    logic              full, room, accept, issue, done_fire, commit, kind_tx;

    // Configuration registers for base and ring size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            size_log2_q <= '0;
        end else if (reg_we) begin
            if (reg_sel == SEL_BASE) base_q      <= reg_wdata;
            if (reg_sel == SEL_SIZE) size_log2_q <= reg_wdata[LOG_W-1:0];
        end
    end

    // Handshake decode for requests and responses.
    always_comb begin
        req_ready  = !dma_valid && room;
        accept     = req_valid && req_ready;
        issue      = accept && !full;
        req_reject = accept && full;
        done_ready = !evt_valid;
        done_fire  = done_valid && done_ready;
        commit     = done_fire && (done_tag == head_ptr);
    end

    cpl_ptr_track #(.PTR_W(PTR_W), .LOG_W(LOG_W), .OUT_LOG(OUT_LOG)) i_ptr (
        .clk(clk), .rst_n(rst_n),
        .tail_we(reg_we && reg_sel == SEL_TAIL), .tail_in(reg_wdata[PTR_W-1:0]),
        .size_log2(size_log2_q), .issue(issue), .commit(commit),
        .spec_head(spec_head), .cmt_head(head_ptr), .full(full), .room(room)
    );

    cpl_addr_gen #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .LOG_W(LOG_W), .REC_LOG2(REC_LOG2)) i_addr (
        .base(base_q), .size_log2(size_log2_q), .ptr(spec_head), .slot_addr(slot_addr)
    );

    cpl_kind_store #(.OUT_LOG(OUT_LOG)) i_kind (
        .clk(clk), .rst_n(rst_n), .wr_en(issue), .wr_idx(spec_head[OUT_LOG-1:0]),
        .wr_is_tx(req_is_tx), .rd_idx(done_tag[OUT_LOG-1:0]), .rd_is_tx(kind_tx)
    );

    // DMA request register: loads on issue, clears when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_valid <= 1'b0;
            dma_addr  <= '0;
            dma_type  <= OP_DESC_FETCH;
            dma_tag   <= '0;
            dma_index <= '0;
            dma_len   <= '0;
        end else if (issue) begin
            dma_valid <= 1'b1;
            dma_addr  <= slot_addr;
            dma_type  <= req_is_tx ? OP_TX_CPL : OP_RX_CPL;
            dma_tag   <= spec_head;
            dma_index <= req_index;
            dma_len   <= req_len;
        end else if (dma_ready) begin
            dma_valid <= 1'b0;
        end
    end

    // Event register and sticky order error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_kind  <= EV_TX_DONE;
            tag_err   <= 1'b0;
        end else begin
            if (commit) begin
                evt_valid <= 1'b1;
                evt_kind  <= kind_tx ? EV_TX_DONE : EV_RX_DONE;
            end else if (evt_ready) begin
                evt_valid <= 1'b0;
            end
            if (done_fire && !commit) tag_err <= 1'b1;
        end
    end
endmodule

// File: rtl/cpl_ring_writer_chk.sv
`timescale 1ns/1ps
// Module: cpl_ring_writer_chk
// Cycle-by-cycle protocol checks on the top-level ports, bound to the top.
module cpl_ring_writer_chk #(
    parameter int ADDR_W = 64,
    parameter int PTR_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PTR_W-1:0]  head_ptr,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_reject,
    input logic              dma_valid,
    input logic              dma_ready,
    input logic [ADDR_W-1:0] dma_addr,
    input logic [2:0]        dma_type,
    input logic [PTR_W-1:0]  dma_tag,
    input logic              done_valid,
    input logic              done_ready,
    input logic [PTR_W-1:0]  done_tag,
    input logic              evt_valid,
    input logic              evt_ready,
    input logic              evt_kind,
    input logic              tag_err
);
    AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid && !dma_ready |=> dma_valid && $stable({dma_addr, dma_type, dma_tag})); // R9
    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid |-> !req_ready); // R9
    AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid |-> (dma_type == 3'd2 || dma_type == 3'd3)); // R3
    AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_reject |=> !dma_valid); // R5
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (head_ptr == $past(head_ptr) || head_ptr == $past(head_ptr) + 1'b1)); // R6
    AST_EVT_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_ready && done_tag == head_ptr |=> evt_valid); // R6
    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_ready |=> evt_valid && $stable(evt_kind)); // R11
    AST_EVT_BLOCKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> !done_ready); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tag_err |=> tag_err); // R8
endmodule

bind cpl_ring_writer cpl_ring_writer_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr), .req_valid(req_valid),
    .req_ready(req_ready), .req_reject(req_reject), .dma_valid(dma_valid),
    .dma_ready(dma_ready), .dma_addr(dma_addr), .dma_type(dma_type), .dma_tag(dma_tag),
    .done_valid(done_valid), .done_ready(done_ready), .done_tag(done_tag),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind), .tag_err(tag_err)
);

// File: tb/test_cpl_ring_writer.sv
`timescale 1ns/1ps
// Directed bench for cpl_ring_writer: one task per scenario.
module test_cpl_ring_writer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [63:0] reg_wdata;
    logic [15:0] head_ptr;
    logic        req_valid, req_ready, req_is_tx, req_reject;
    logic [15:0] req_index, req_len;
    logic        dma_valid, dma_ready;
    logic [63:0] dma_addr;
    logic [2:0]  dma_type;
    logic [15:0] dma_tag, dma_index, dma_len;
    logic        done_valid, done_ready;
    logic [15:0] done_tag;
    logic        evt_valid, evt_ready, evt_kind, tag_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cpl_ring_writer i_cpl_ring_writer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .head_ptr(head_ptr), .req_valid(req_valid), .req_ready(req_ready),
        .req_index(req_index), .req_len(req_len), .req_is_tx(req_is_tx),
        .req_reject(req_reject), .dma_valid(dma_valid), .dma_ready(dma_ready),
        .dma_addr(dma_addr), .dma_type(dma_type), .dma_tag(dma_tag),
        .dma_index(dma_index), .dma_len(dma_len), .done_valid(done_valid),
        .done_ready(done_ready), .done_tag(done_tag), .evt_valid(evt_valid),
        .evt_ready(evt_ready), .evt_kind(evt_kind), .tag_err(tag_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [63:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Presents one request for one cycle; checks ready and reject in that cycle.
    task automatic send_req(input bit tx, input logic [15:0] idx, input logic [15:0] len,
                            input bit exp_reject);
        @(negedge clk);
        req_valid = 1'b1; req_is_tx = tx; req_index = idx; req_len = len;
        #1;
        check("R9 ready", req_ready, 1'b1);
        check("R5 reject", req_reject, exp_reject);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Checks the pending DMA write and then takes it.
    task automatic take_dma(input logic [63:0] addr, input logic [2:0] typ, input logic [15:0] tag,
                            input logic [15:0] idx, input logic [15:0] len);
        check("R4 valid", dma_valid, 1'b1);
        check("R2 addr", dma_addr, addr);
        check("R3 type", dma_type, typ);
        check("R4 tag", dma_tag, tag);
        check("R3 index", dma_index, idx);
        check("R3 len", dma_len, len);
        dma_ready = 1'b1;
        @(negedge clk);
        dma_ready = 1'b0;
    endtask

    task automatic respond(input logic [15:0] tag);
        @(negedge clk);
        done_valid = 1'b1; done_tag = tag;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic take_evt(input bit kind);
        check("R6 evt", evt_valid, 1'b1);
        check("R7 kind", evt_kind, kind);
        check("R11 done blocked", done_ready, 1'b0);
        evt_ready = 1'b1;
        @(negedge clk);
        evt_ready = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 head", head_ptr, 16'd0);
        check("R1 dma", dma_valid, 1'b0);
        check("R1 evt", evt_valid, 1'b0);
        check("R1 err", tag_err, 1'b0);
        check("R1 ready", req_ready, 1'b1);
    endtask

    task automatic t_issue();
        cfg(2'd0, 64'h1000);
        cfg(2'd1, 64'd2);
        cfg(2'd2, 64'd0);
        send_req(1'b1, 16'd5, 16'd100, 1'b0);
        // R9: hold under back-pressure for three cycles
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 hold valid", dma_valid, 1'b1);
            check("R9 hold addr", dma_addr, 64'h1000);
            check("R9 busy", req_ready, 1'b0);
        end
        take_dma(64'h1000, 3'd2, 16'd0, 16'd5, 16'd100);
        send_req(1'b0, 16'd9, 16'd64, 1'b0);
        take_dma(64'h1020, 3'd3, 16'd1, 16'd9, 16'd64);
    endtask

    task automatic t_commit();
        respond(16'd0);
        check("R6 head", head_ptr, 16'd1);
        // R11: event held while not taken
        @(negedge clk);
        check("R11 held", evt_valid, 1'b1);
        take_evt(1'b0);
        respond(16'd1);
        check("R6 head", head_ptr, 16'd2);
        take_evt(1'b1);
    endtask

    task automatic t_mismatch();
        respond(16'd7);
        check("R8 err", tag_err, 1'b1);
        check("R8 head", head_ptr, 16'd2);
        check("R8 no evt", evt_valid, 1'b0);
    endtask

    task automatic t_full();
        send_req(1'b1, 16'd1, 16'd10, 1'b0);
        take_dma(64'h1040, 3'd2, 16'd2, 16'd1, 16'd10);
        send_req(1'b0, 16'd2, 16'd20, 1'b0);
        take_dma(64'h1060, 3'd3, 16'd3, 16'd2, 16'd20);
        send_req(1'b1, 16'd3, 16'd30, 1'b1);
        check("R5 no dma", dma_valid, 1'b0);
        cfg(2'd2, 64'd2);
        send_req(1'b1, 16'd4, 16'd40, 1'b0);
        take_dma(64'h1000, 3'd2, 16'd4, 16'd4, 16'd40);
    endtask

    task automatic t_window();
        cfg(2'd1, 64'd10);
        for (int i = 0; i < 5; i++) begin
            send_req(1'b0, 16'(i), 16'd8, 1'b0);
            take_dma(64'h1000 + 64'((5 + i) * 32), 3'd3, 16'(5 + i), 16'(i), 16'd8);
        end
        @(negedge clk);
        check("R10 window full", req_ready, 1'b0);
        respond(16'd2);
        check("R6 head", head_ptr, 16'd3);
        take_evt(1'b0);
        check("R10 window open", req_ready, 1'b1);
    endtask

    task automatic t_tail_ahead();
        cfg(2'd2, 64'd11);
        send_req(1'b1, 16'd0, 16'd1, 1'b1);
        check("R5 no dma", dma_valid, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
        req_valid = 1'b0; req_is_tx = 1'b0; req_index = '0; req_len = '0;
        dma_ready = 1'b0; done_valid = 1'b0; done_tag = '0; evt_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_issue();
        t_commit();
        t_mismatch();
        t_full();
        t_window();
        t_tail_ahead();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule